// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block turns a software write of a 64-bit interrupt command into the deliveries that command asks for. The command is written as two 32-bit words. The high word carries the destination byte. The low word carries the vector, the delivery mode, the destination mode, the level, the trigger and the destination shorthand. Writing the low word starts a send. The shorthand, or the physical or logical address, is expanded into a mask of processors. The local processor's own slot is split off and delivered on a one-cycle local loopback strobe. The remaining targets go out one message per accepted cycle on a valid/ready port.

A delivery-status (busy) bit is set whenever at least one remote message is launched. An outstanding counter is loaded with the number of remote messages. Each completion pulse from the interconnect decrements the counter, and the busy bit drops when the counter reaches zero. While busy, further low-word writes are dropped.

Two companion registers, the logical destination and the destination format, have fixed write masks. Their contents are shown on read-back ports.

Top module: `ipi_dispatch`

## Requirements
- R1: Every remote message carries the latched command's fields. The vector is low bits 7:0, the delivery mode bits 10:8, the destination mode bit 11 (1 = logical), the level bit 14 and the trigger bit 15. The destination byte is high-word bits 31:24.
- R2: A low-word write (wrSel = 0) while busy is set does not change the stored command, produces no local strobe and launches no message.
- R3: With shorthand 0 (bits 19:18) and logical mode, processor i is a target exactly when bit i of the destination byte is set.
- R4: With shorthand 0 and physical mode, destination 0xFF targets every processor. Any other value targets only the processor whose ID equals it, or none if no such processor exists.
- R5: A target whose ID equals localId is never sent remotely. Instead, localValid pulses for one cycle after the launching write, with the command's vector, mode and trigger.
- R6: Shorthand 1 (self) gives only a local delivery. Shorthand 2 (all including self) gives a local delivery and remote messages to every other processor. Shorthand 3 (all excluding self) gives remote messages to every other processor only.
- R7: If at least one remote message is launched, busy is set in the cycle after the write, and low-word read-back bit 12 shows it. A launch with no remote target leaves busy clear.
- R8: Busy stays set until the number of doneIn pulses equals the number of remote messages launched, and it clears in the cycle after the last one.
- R9: A write to the logical destination register (wrSel = 2) keeps only bits 31:24 and clears the rest. A write to the destination format register (wrSel = 3) stores the data with bits 27:0 forced to ones. The destination format register resets to all ones.
- R10: Remote messages leave one per accepted cycle in ascending processor-ID order. A message offered with txReady low is held unchanged.
- R11: Delivery mode 1 (lowest priority) is emitted as mode 0 (fixed) on both the local and the remote outputs. Other modes pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localId | input | 8 | ID of the local processor |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 command low, 1 command high, 2 logical destination, 3 destination format |
| wrData | input | 32 | Write data |
| cmdLoWord | output | 32 | Command low word read-back, bit 12 = busy |
| cmdHiWord | output | 32 | Command high word read-back |
| logDestWord | output | 32 | Logical destination register read-back |
| destFmtWord | output | 32 | Destination format register read-back |
| busy | output | 1 | Delivery status: remote messages still outstanding |
| localValid | output | 1 | One-cycle local loopback delivery strobe |
| localVector | output | 8 | Vector of the local delivery |
| localMode | output | 3 | Delivery mode of the local delivery |
| localTrigger | output | 1 | Trigger of the local delivery |
| txValid | output | 1 | Remote message valid |
| txReady | input | 1 | Interconnect accepts the remote message |
| txTarget | output | 8 | Processor ID the message is addressed to |
| txDest | output | 8 | Destination byte field of the message |
| txVector | output | 8 | Vector field |
| txMode | output | 3 | Delivery mode field |
| txDestMode | output | 1 | Destination mode field |
| txLevel | output | 1 | Level field |
| txTrigger | output | 1 | Trigger field |
| doneIn | input | 1 | One pulse per completed remote message |

## Verification
The checker watches properties on every cycle. A stalled message holds its target and fields. No message is ever addressed to the local ID, and no message carries the lowest-priority mode. txValid implies busy. Busy falls only right after a completion. A busy-time command write changes nothing. The register write masks take effect. Which processors a shorthand or address selects, the strict ascending order, the exact message count and the count of completions needed to clear busy depend on the whole command. Only the bench's scenarios show these, by comparing every offered message and every local strobe against an independently computed target list.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SEL_CMD_LO   = 2'd0,
    SEL_CMD_HI   = 2'd1,
    SEL_LOG_DEST = 2'd2,
    SEL_DEST_FMT = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    SH_NONE     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL_INCL = 2'd2,
    SH_ALL_EXCL = 2'd3
  } shorthand_e;

  localparam int VEC_LSB    = 0;
  localparam int MODE_LSB   = 8;
  localparam int DMODE_BIT  = 11;
  localparam int STATUS_BIT = 12;
  localparam int LEVEL_BIT  = 14;
  localparam int TRIG_BIT   = 15;
  localparam int SH_LSB     = 18;
  localparam int DEST_LSB   = 24;

  localparam logic [2:0] MODE_FIXED   = 3'd0;
  localparam logic [2:0] MODE_LOWPRIO = 3'd1;

  typedef struct packed {
    logic loadCmdLo;
    logic loadCmdHi;
    logic loadLogDest;
    logic loadDestFmt;
    logic launch;
    logic txFire;
    logic retire;
  } ipiStrobe_t;

  function automatic logic [2:0] mapMode(input logic [2:0] m);
    return (m == MODE_LOWPRIO) ? MODE_FIXED : m;
  endfunction

endpackage

// File: rtl/ipi_target_decode.sv
module ipi_target_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int ID_W     = 8
) (
  input  logic [1:0]          shorthand,
  input  logic                destMode,
  input  logic [7:0]          destByte,
  input  logic [ID_W-1:0]     localId,
  output logic [NUM_CPUS-1:0] remoteMask,
  output logic                localHit
);

  logic [NUM_CPUS-1:0] addrMask;
  logic                addrSelf;

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    logic physHit;
    logic logHit;
    logic isSelf;
    assign physHit = (destByte == 8'hFF) || (ID_W'(destByte) == ID_W'(i));
    if (i < 8) begin : g_logic_bit
      assign logHit = destByte[i];
    end else begin : g_no_logic_bit
      assign logHit = 1'b0;
    end
    assign isSelf = (localId == ID_W'(i));

    always_comb begin
      addrMask[i] = destMode ? logHit : physHit;
      unique case (shorthand_e'(shorthand))
        SH_NONE:     remoteMask[i] = addrMask[i] && !isSelf;
        SH_SELF:     remoteMask[i] = 1'b0;
        SH_ALL_INCL: remoteMask[i] = !isSelf;
        SH_ALL_EXCL: remoteMask[i] = !isSelf;
        default:     remoteMask[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (destMode) begin
      addrSelf = (localId < ID_W'(8)) ? destByte[localId[2:0]] : 1'b0;
    end else begin
      addrSelf = (destByte == 8'hFF) || (ID_W'(destByte) == localId);
    end
    unique case (shorthand_e'(shorthand))
      SH_NONE:     localHit = addrSelf;
      SH_SELF:     localHit = 1'b1;
      SH_ALL_INCL: localHit = 1'b1;
      SH_ALL_EXCL: localHit = 1'b0;
      default:     localHit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_control.sv
module ipi_control
  import ipi_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] launchCount,
  input  logic             pendingAny,
  input  logic             txReady,
  input  logic             doneIn,
  output ipiStrobe_t       strobe,
  output logic             busy
);

  logic [CNT_W-1:0] outstanding;
  logic [CNT_W-1:0] outstandingNext;

  assign busy = (outstanding != '0);

  always_comb begin
    strobe             = '0;
    strobe.launch      = wrEn && (regSel_e'(wrSel) == SEL_CMD_LO) && !busy;
    strobe.loadCmdLo   = strobe.launch;
    strobe.loadCmdHi   = wrEn && (regSel_e'(wrSel) == SEL_CMD_HI);
    strobe.loadLogDest = wrEn && (regSel_e'(wrSel) == SEL_LOG_DEST);
    strobe.loadDestFmt = wrEn && (regSel_e'(wrSel) == SEL_DEST_FMT);
    strobe.txFire      = pendingAny && txReady;
    strobe.retire      = doneIn && busy;
  end

  always_comb begin
    outstandingNext = outstanding;
    if (strobe.launch) begin
      outstandingNext = outstandingNext + launchCount;
    end
    if (strobe.retire) begin
      outstandingNext = outstandingNext - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
    end else begin
      outstanding <= outstandingNext;
    end
  end

endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int ID_W     = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ipiStrobe_t       strobe,
  input  logic [31:0]      wrData,
  input  logic [ID_W-1:0]  localId,
  input  logic             busy,
  output logic [CNT_W-1:0] launchCount,
  output logic             pendingAny,
  output logic [31:0]      cmdLoWord,
  output logic [31:0]      cmdHiWord,
  output logic [31:0]      logDestWord,
  output logic [31:0]      destFmtWord,
  output logic             localValid,
  output logic [7:0]       localVector,
  output logic [2:0]       localMode,
  output logic             localTrigger,
  output logic [ID_W-1:0]  txTarget,
  output logic [7:0]       txDest,
  output logic [7:0]       txVector,
  output logic [2:0]       txMode,
  output logic             txDestMode,
  output logic             txLevel,
  output logic             txTrigger
);

  logic [31:0]         cmdLo;
  logic [31:0]         cmdHi;
  logic [31:0]         logDest;
  logic [31:0]         destFmt;
  logic [NUM_CPUS-1:0] pendingMask;
  logic [7:0]          msgDest;
  logic [NUM_CPUS-1:0] newRemote;
  logic                newLocal;
  logic [ID_W-1:0]     pickIdx;

  ipi_target_decode #(
    .NUM_CPUS(NUM_CPUS),
    .ID_W    (ID_W)
  ) u_decode (
    .shorthand (wrData[SH_LSB +: 2]),
    .destMode  (wrData[DMODE_BIT]),
    .destByte  (cmdHi[DEST_LSB +: 8]),
    .localId   (localId),
    .remoteMask(newRemote),
    .localHit  (newLocal)
  );

  always_comb begin
    launchCount = '0;
    for (int i = 0; i < NUM_CPUS; i++) begin
      launchCount = launchCount + CNT_W'(newRemote[i]);
    end
  end

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_CPUS - 1; i >= 0; i--) begin
      if (pendingMask[i]) begin
        pickIdx = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLo       <= '0;
      cmdHi       <= '0;
      logDest     <= '0;
      destFmt     <= '1;
      pendingMask <= '0;
      msgDest     <= '0;
      localValid  <= 1'b0;
    end else begin
      localValid <= 1'b0;
      if (strobe.loadCmdHi) begin
        cmdHi <= wrData;
      end
      if (strobe.loadLogDest) begin
        logDest <= {wrData[31:24], 24'h0};
      end
      if (strobe.loadDestFmt) begin
        destFmt <= wrData | 32'h0FFF_FFFF;
      end
      if (strobe.txFire) begin
        pendingMask[pickIdx] <= 1'b0;
      end
      if (strobe.launch) begin
        cmdLo       <= wrData & ~(32'h1 << STATUS_BIT);
        msgDest     <= cmdHi[DEST_LSB +: 8];
        pendingMask <= newRemote;
        localValid  <= newLocal;
      end
    end
  end

  assign pendingAny   = (pendingMask != '0);
  assign cmdLoWord    = cmdLo | (32'(busy) << STATUS_BIT);
  assign cmdHiWord    = cmdHi;
  assign logDestWord  = logDest;
  assign destFmtWord  = destFmt;

  assign localVector  = cmdLo[VEC_LSB +: 8];
  assign localMode    = mapMode(cmdLo[MODE_LSB +: 3]);
  assign localTrigger = cmdLo[TRIG_BIT];

  assign txTarget     = pickIdx;
  assign txDest       = msgDest;
  assign txVector     = cmdLo[VEC_LSB +: 8];
  assign txMode       = mapMode(cmdLo[MODE_LSB +: 3]);
  assign txDestMode   = cmdLo[DMODE_BIT];
  assign txLevel      = cmdLo[LEVEL_BIT];
  assign txTrigger    = cmdLo[TRIG_BIT];

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int ID_W     = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ID_W-1:0] localId,
  input  logic            wrEn,
  input  logic [1:0]      wrSel,
  input  logic [31:0]     wrData,
  output logic [31:0]     cmdLoWord,
  output logic [31:0]     cmdHiWord,
  output logic [31:0]     logDestWord,
  output logic [31:0]     destFmtWord,
  output logic            busy,
  output logic            localValid,
  output logic [7:0]      localVector,
  output logic [2:0]      localMode,
  output logic            localTrigger,
  output logic            txValid,
  input  logic            txReady,
  output logic [ID_W-1:0] txTarget,
  output logic [7:0]      txDest,
  output logic [7:0]      txVector,
  output logic [2:0]      txMode,
  output logic            txDestMode,
  output logic            txLevel,
  output logic            txTrigger,
  input  logic            doneIn
);

  localparam int CNT_W = $clog2(NUM_CPUS + 1);

  ipiStrobe_t       strobe;
  logic [CNT_W-1:0] launchCount;
  logic             pendingAny;

  ipi_control #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .launchCount(launchCount),
    .pendingAny (pendingAny),
    .txReady    (txReady),
    .doneIn     (doneIn),
    .strobe     (strobe),
    .busy       (busy)
  );

  ipi_datapath #(
    .NUM_CPUS(NUM_CPUS),
    .ID_W    (ID_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .localId     (localId),
    .busy        (busy),
    .launchCount (launchCount),
    .pendingAny  (pendingAny),
    .cmdLoWord   (cmdLoWord),
    .cmdHiWord   (cmdHiWord),
    .logDestWord (logDestWord),
    .destFmtWord (destFmtWord),
    .localValid  (localValid),
    .localVector (localVector),
    .localMode   (localMode),
    .localTrigger(localTrigger),
    .txTarget    (txTarget),
    .txDest      (txDest),
    .txVector    (txVector),
    .txMode      (txMode),
    .txDestMode  (txDestMode),
    .txLevel     (txLevel),
    .txTrigger   (txTrigger)
  );

  assign txValid = pendingAny;

endmodule

// File: rtl/ipi_dispatch_checker.sv
module ipi_dispatch_checker #(
  parameter int NUM_CPUS = 8,
  parameter int ID_W     = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [ID_W-1:0] localId,
  input logic            wrEn,
  input logic [1:0]      wrSel,
  input logic [31:0]     cmdLoWord,
  input logic [31:0]     logDestWord,
  input logic [31:0]     destFmtWord,
  input logic            busy,
  input logic            localValid,
  input logic            txValid,
  input logic            txReady,
  input logic [ID_W-1:0] txTarget,
  input logic [7:0]      txVector,
  input logic [2:0]      txMode,
  input logic            txLevel,
  input logic            txTrigger,
  input logic            doneIn
);

  // R10: a stalled offer keeps its target and fields
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txTarget) && $stable(txVector)
                               && $stable(txMode) && $stable(txLevel) && $stable(txTrigger)));

  // R5: nothing is ever sent remotely to the local processor
  p_no_self_send_r5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txTarget != localId));

  // R11: lowest-priority mode never leaves as such
  p_no_lowprio_r11: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txMode != 3'd1));

  // R7: an offered message implies outstanding status
  p_valid_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy);

  // R8: busy only drops right after a completion
  p_fall_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(doneIn));

  // R2: a command write while busy changes nothing
  p_busy_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0 && busy) |=> (!localValid && $stable(cmdLoWord & ~32'h1000)));

  // R9: logical destination keeps only its top byte
  p_log_dest_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2) |=> (logDestWord[23:0] == 24'h0));

  // R9: destination format low bits forced to ones
  p_dest_fmt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd3) |=> (destFmtWord[27:0] == 28'hFFF_FFFF));

endmodule

bind ipi_dispatch ipi_dispatch_checker #(.NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_chk (.*);

// File: tb/ipi_dispatch_test.sv
`timescale 1ns/1ps
module ipi_dispatch_test;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  localId;
  logic        wrEn;
  logic [1:0]  wrSel;
  logic [31:0] wrData;
  logic [31:0] cmdLoWord, cmdHiWord, logDestWord, destFmtWord;
  logic        busy, localValid, localTrigger;
  logic [7:0]  localVector;
  logic [2:0]  localMode;
  logic        txValid, txReady;
  logic [7:0]  txTarget, txDest, txVector;
  logic [2:0]  txMode;
  logic        txDestMode, txLevel, txTrigger;
  logic        doneIn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  ipi_dispatch #(.NUM_CPUS(N), .ID_W(8)) uut (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected targets: bit N = local delivery, bits N-1:0 = remote mask
  function automatic logic [N:0] refTargets(input logic [31:0] lo, input logic [7:0] dest,
                                            input logic [7:0] lid);
    logic [N-1:0] tgt;
    logic [N-1:0] selfBit;
    logic         loc;
    selfBit = (lid < 8'(N)) ? (N'(1) << lid) : '0;
    tgt = '0;
    loc = 1'b0;
    case (lo[19:18])
      2'd1: begin tgt = '0; loc = 1'b1; end
      2'd2: begin tgt = '1; loc = 1'b1; end
      2'd3: begin tgt = '1; loc = 1'b0; end
      default: begin
        if (lo[11]) begin
          tgt = dest[N-1:0];
          loc = (lid < 8'd8) ? dest[lid[2:0]] : 1'b0;
        end else if (dest == 8'hFF) begin
          tgt = '1;
          loc = 1'b1;
        end else begin
          tgt = (dest < 8'(N)) ? (N'(1) << dest) : '0;
          loc = (dest == lid);
        end
      end
    endcase
    return {loc, tgt & ~selfBit};
  endfunction

  function automatic logic [2:0] refMode(input logic [2:0] m);
    return (m == 3'd1) ? 3'd0 : m;
  endfunction

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runCommand(input logic [31:0] lo, input logic [7:0] dest,
                            input logic [7:0] lid, input bit injectBusyWrite);
    logic [N:0]   exp;
    logic [N-1:0] rem;
    int           nExp;
    int           idx;
    int           cyc;
    int           order [N];
    logic [31:0]  expLo;
    localId = lid;
    writeReg(2'd1, {dest, 24'h0});
    exp = refTargets(lo, dest, lid);
    rem = exp[N-1:0];
    nExp = 0;
    for (int i = 0; i < N; i++) if (rem[i]) begin order[nExp] = i; nExp++; end
    writeReg(2'd0, lo);
    expLo = lo & ~32'h1000;
    check(localValid == exp[N], "R5/R6", "local strobe", 32'(localValid), 32'(exp[N]));
    if (exp[N]) begin
      check(localVector == lo[7:0], "R5", "local vector", 32'(localVector), 32'(lo[7:0]));
      check(localMode == refMode(lo[10:8]), "R11", "local mode", 32'(localMode),
            32'(refMode(lo[10:8])));
    end
    check(busy == (nExp != 0), "R7", "busy after launch", 32'(busy), 32'(nExp != 0));
    check(cmdLoWord == (expLo | (32'(nExp != 0) << 12)), "R7", "low read-back",
          cmdLoWord, expLo | (32'(nExp != 0) << 12));
    if (injectBusyWrite && nExp != 0) begin
      writeReg(2'd0, lo ^ 32'h0000_00FF);
      check(localValid == 1'b0, "R2", "no local strobe when busy", 32'(localValid), 32'h0);
      check((cmdLoWord & ~32'h1000) == expLo, "R2", "command kept when busy",
            cmdLoWord & ~32'h1000, expLo);
    end
    idx = 0;
    cyc = 0;
    while (idx < nExp && cyc < 400) begin
      txReady = ($urandom % 3) != 0;
      if (txValid && txReady) begin
        check(txTarget == 8'(order[idx]), "R10/R3/R4/R6", "target order",
              32'(txTarget), 32'(order[idx]));
        check(txVector == lo[7:0] && txDest == dest && txDestMode == lo[11] &&
              txLevel == lo[14] && txTrigger == lo[15], "R1", "message fields",
              {txDest, txVector, 13'h0, txDestMode, txLevel, txTrigger},
              {dest, lo[7:0], 13'h0, lo[11], lo[14], lo[15]});
        check(txMode == refMode(lo[10:8]), "R11", "remote mode", 32'(txMode),
              32'(refMode(lo[10:8])));
        idx++;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    txReady = 1'b0;
    check(idx == nExp, "R10", "message count", 32'(idx), 32'(nExp));
    check(txValid == 1'b0, "R10", "no extra message", 32'(txValid), 32'h0);
    for (int k = 0; k < nExp; k++) begin
      check(busy == 1'b1, "R8", "busy before last completion", 32'(busy), 32'h1);
      repeat ($urandom % 3) begin @(posedge clk); @(negedge clk); end
      doneIn = 1'b1;
      @(posedge clk);
      @(negedge clk);
      doneIn = 1'b0;
    end
    check(busy == 1'b0, "R8", "busy cleared", 32'(busy), 32'h0);
    check(cmdLoWord[12] == 1'b0, "R8", "status bit cleared", 32'(cmdLoWord[12]), 32'h0);
  endtask

  function automatic logic [31:0] mkLo(input logic [1:0] sh, input bit dm, input logic [2:0] mode,
                                       input logic [7:0] vec, input bit lvl, input bit trg);
    return {12'h0, sh, 2'b00, trg, lvl, 1'b0, 1'b0, dm, mode, vec};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rstN = 1'b0; localId = 8'd3; wrEn = 1'b0; wrSel = 2'd0; wrData = '0;
    txReady = 1'b0; doneIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R9, R7)
    check(busy == 1'b0, "R7", "reset busy", 32'(busy), 32'h0);
    check(txValid == 1'b0, "R10", "reset txValid", 32'(txValid), 32'h0);
    check(destFmtWord == 32'hFFFF_FFFF, "R9", "reset destination format", destFmtWord,
          32'hFFFF_FFFF);

    // R9 register masks
    writeReg(2'd2, 32'h1234_5678);
    check(logDestWord == 32'h1200_0000, "R9", "logical destination mask", logDestWord,
          32'h1200_0000);
    writeReg(2'd3, 32'hA000_0003);
    check(destFmtWord == 32'hAFFF_FFFF, "R9", "destination format mask", destFmtWord,
          32'hAFFF_FFFF);

    // directed corners
    runCommand(mkLo(2'd0, 1'b0, 3'd0, 8'h41, 1'b1, 1'b0), 8'hFF, 8'd3, 1'b1); // R4 broadcast, R2
    runCommand(mkLo(2'd0, 1'b0, 3'd0, 8'h42, 1'b0, 1'b1), 8'd5, 8'd3, 1'b0);  // R4 unicast
    runCommand(mkLo(2'd0, 1'b0, 3'd4, 8'h43, 1'b0, 1'b0), 8'd3, 8'd3, 1'b0);  // R5 self by ID
    runCommand(mkLo(2'd0, 1'b0, 3'd0, 8'h44, 1'b0, 1'b0), 8'd20, 8'd3, 1'b0); // R4 no such ID
    runCommand(mkLo(2'd0, 1'b1, 3'd1, 8'h45, 1'b1, 1'b1), 8'hA9, 8'd3, 1'b0); // R3 logical, R11
    runCommand(mkLo(2'd1, 1'b0, 3'd1, 8'h46, 1'b0, 1'b0), 8'd0, 8'd3, 1'b0);  // R6 self
    runCommand(mkLo(2'd2, 1'b0, 3'd2, 8'h47, 1'b0, 1'b0), 8'd0, 8'd0, 1'b1);  // R6 all incl
    runCommand(mkLo(2'd3, 1'b0, 3'd5, 8'h48, 1'b1, 1'b1), 8'd0, 8'd7, 1'b0);  // R6 all excl

    // constrained random
    for (int t = 0; t < 60; t++) begin
      logic [7:0] d;
      case ($urandom % 4)
        0: d = 8'hFF;
        1: d = 8'($urandom % N);
        default: d = 8'($urandom);
      endcase
      runCommand(mkLo(2'($urandom), 1'($urandom), 3'($urandom), 8'($urandom),
                      1'($urandom), 1'($urandom)), d, 8'($urandom % N), ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule